// File: doc/BRIEF.md
# Deferred-Fault Register File with Poison Tags

This block is a general-purpose register file in which every entry carries one extra tag bit. The bit marks the entry as holding an invalid result from a speculative operation that faulted. When a speculative instruction hits a fault that would end the program, it does not trap at once. It tags its destination register instead. The fault is then raised later, and only if the value is actually used.

The write port carries the destination index and the data. It also carries a speculative flag, a fault flag and a fault-class flag; the class says whether the fault would end the program or can be resumed. Some faults cannot wait: any fault on a non-speculative write, and a resumable fault on a speculative write. These are reported at once on the trap output. Two read ports return the data and the tag of the selected register. A non-speculative read of a tagged register raises an exception event that names the register. A speculative read of a tagged register only passes the tag on to the consumer. A separate check port tests one register, and if its tag is set it asks for recovery.

Read data and tags are combinational from the stored state. The trap, exception and recovery events are registered and appear one clock after the request. Reset is asserted asynchronously and is released through a two-stage synchroniser.

Top module: `deferred_fault_regfile`

## Requirements
- R1: While reset is asserted, and once it has been released, every register reads data 0 with its tag clear, and trap_valid, exc_valid and recov_req are low.
- R2: A write with wr_fault=0 stores wr_data into register wr_idx and clears that register's tag. This holds whether wr_spec is 0 or 1. The new value is visible on the read ports from the clock after the write.
- R3: A write with wr_fault=1, wr_spec=1 and wr_fatal=1 sets the tag of register wr_idx. The stored data is left unchanged and no trap is raised.
- R4: A write with wr_fault=1 where wr_spec=0 or wr_fatal=0 leaves both the data and the tag of the register unchanged. One clock later it raises trap_valid for one cycle, with trap_idx equal to wr_idx.
- R5: A read with rdN_en=1 and rdN_spec=0 of a tagged register raises exc_valid for one cycle, one clock later, with exc_idx equal to the register index that was read.
- R6: A read with rdN_spec=1 of a tagged register shows rdN_poison=1 and raises no exception.
- R7: If both read ports make a non-speculative read of tagged registers in the same cycle, a single exception is raised, and exc_idx holds the port 0 index.
- R8: A check with chk_en=1 on a tagged register raises recov_req one clock later, with recov_idx equal to chk_idx. A check on an untagged register raises nothing.
- R9: A read with rdN_en=0 raises no exception, whatever the tag of the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register |
| wr_data | input | DATA_W | Write data |
| wr_spec | input | 1 | Writer is a speculative instruction |
| wr_fault | input | 1 | Writer took a fault |
| wr_fatal | input | 1 | Fault class: 1 = program-terminating, 0 = resumable |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_spec | input | 1 | Read port 0 reader is speculative |
| rd0_idx | input | IDX_W | Read port 0 register |
| rd0_data | output | DATA_W | Read port 0 data |
| rd0_poison | output | 1 | Read port 0 tag |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_spec | input | 1 | Read port 1 reader is speculative |
| rd1_idx | input | IDX_W | Read port 1 register |
| rd1_data | output | DATA_W | Read port 1 data |
| rd1_poison | output | 1 | Read port 1 tag |
| chk_en | input | 1 | Check request |
| chk_idx | input | IDX_W | Register to check |
| trap_valid | output | 1 | Immediate fault event |
| trap_idx | output | IDX_W | Register of the immediate fault |
| exc_valid | output | 1 | Deferred exception event |
| exc_idx | output | IDX_W | Register whose tagged value was used |
| recov_req | output | 1 | Recovery request from a check |
| recov_idx | output | IDX_W | Register that failed the check |

## Verification
The assertions assume that wr_spec, wr_fault and wr_fatal matter only while wr_en is high, and that each index lies below NUM_REGS. The stimulus keeps both conditions and drives every control input to a defined 0 from time zero. The properties that compare the cycle after a write with the cycle of the write take it that only one write lands per clock. The bench applies each vector for exactly one cycle and idles the write port between the directed steps. That way an event seen after a clock can be traced to a single request.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_STORE  = 2'd1,
    WR_POISON = 2'd2,
    WR_TRAP   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/dfr_write_ctl.sv
module dfr_write_ctl
  import dfr_pkg::*;
(
  input  logic     wr_en,
  input  logic     wr_spec,
  input  logic     wr_fault,
  input  logic     wr_fatal,
  output wr_kind_e kind
);
  always_comb begin
    kind = WR_NONE;
    if (wr_en) begin
      if (!wr_fault)                 kind = WR_STORE;
      else if (wr_spec && wr_fatal)  kind = WR_POISON;
      else                           kind = WR_TRAP;
    end
  end
endmodule

// File: rtl/dfr_storage.sv
module dfr_storage
  import dfr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  wr_kind_e                         kind,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  data_q,
  output logic [NUM_REGS-1:0]              pois_q
);
  logic [NUM_REGS-1:0][DATA_W-1:0] data_d;
  logic [NUM_REGS-1:0]             pois_d;
  logic [NUM_REGS-1:0]             data_ce;
  logic [NUM_REGS-1:0]             pois_ce;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic hit;
    assign hit = (wr_idx == IDX_W'(i));

    always_comb begin
      data_ce[i] = hit && (kind == WR_STORE);
      pois_ce[i] = hit && ((kind == WR_STORE) || (kind == WR_POISON));
      data_d[i]  = wr_data;
      pois_d[i]  = (kind == WR_POISON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
      end else if (data_ce[i]) begin
        data_q[i] <= data_d[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pois_q[i] <= 1'b0;
      end else if (pois_ce[i]) begin
        pois_q[i] <= pois_d[i];
      end
    end
  end

  assert_store_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_STORE) |=> (!pois_q[$past(wr_idx)] && data_q[$past(wr_idx)] == $past(wr_data)));

  assert_poison_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_POISON) |=> (pois_q[$past(wr_idx)] && data_q[$past(wr_idx)] == $past(data_q[wr_idx])));

  assert_trap_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_TRAP) |=> ($stable(pois_q) && $stable(data_q)));
endmodule

// File: rtl/dfr_event_gen.sv
module dfr_event_gen #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd0_hit,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic             rd1_hit,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic             chk_en,
  input  logic             chk_poison,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             trap_req,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             exc_valid,
  output logic [IDX_W-1:0] exc_idx,
  output logic             recov_req,
  output logic [IDX_W-1:0] recov_idx,
  output logic             trap_valid,
  output logic [IDX_W-1:0] trap_idx
);
  logic             exc_d, recov_d;
  logic [IDX_W-1:0] exc_idx_d;

  always_comb begin
    exc_d     = rd0_hit || rd1_hit;
    exc_idx_d = rd0_hit ? rd0_idx : rd1_idx;
    recov_d   = chk_en && chk_poison;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid  <= 1'b0;
      recov_req  <= 1'b0;
      trap_valid <= 1'b0;
    end else begin
      exc_valid  <= exc_d;
      recov_req  <= recov_d;
      trap_valid <= trap_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_idx <= '0;
    end else if (exc_d) begin
      exc_idx <= exc_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recov_idx <= '0;
    end else if (recov_d) begin
      recov_idx <= chk_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_idx <= '0;
    end else if (trap_req) begin
      trap_idx <= wr_idx;
    end
  end

  assert_recov_needs_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recov_req |-> ($past(chk_en) && recov_idx == $past(chk_idx)));

  assert_port0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_hit && rd1_hit) |=> (exc_valid && exc_idx == $past(rd0_idx)));
endmodule

// File: rtl/deferred_fault_regfile.sv
module deferred_fault_regfile
  import dfr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_spec,
  input  logic              wr_fault,
  input  logic              wr_fatal,
  input  logic              rd0_en,
  input  logic              rd0_spec,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_poison,
  input  logic              rd1_en,
  input  logic              rd1_spec,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_poison,
  input  logic              chk_en,
  input  logic [IDX_W-1:0]  chk_idx,
  output logic              trap_valid,
  output logic [IDX_W-1:0]  trap_idx,
  output logic              exc_valid,
  output logic [IDX_W-1:0]  exc_idx,
  output logic              recov_req,
  output logic [IDX_W-1:0]  recov_idx
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  wr_kind_e                        kind;
  logic [NUM_REGS-1:0][DATA_W-1:0] data_q;
  logic [NUM_REGS-1:0]             pois_q;
  logic                            rd0_hit, rd1_hit;

  dfr_write_ctl u_wctl (
    .wr_en    (wr_en),
    .wr_spec  (wr_spec),
    .wr_fault (wr_fault),
    .wr_fatal (wr_fatal),
    .kind     (kind)
  );

  dfr_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .kind    (kind),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .data_q  (data_q),
    .pois_q  (pois_q)
  );

  always_comb begin
    rd0_data   = data_q[rd0_idx];
    rd0_poison = pois_q[rd0_idx];
    rd1_data   = data_q[rd1_idx];
    rd1_poison = pois_q[rd1_idx];
    rd0_hit    = rd0_en && !rd0_spec && rd0_poison;
    rd1_hit    = rd1_en && !rd1_spec && rd1_poison;
  end

  dfr_event_gen #(.NUM_REGS(NUM_REGS)) u_evt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd0_hit    (rd0_hit),
    .rd0_idx    (rd0_idx),
    .rd1_hit    (rd1_hit),
    .rd1_idx    (rd1_idx),
    .chk_en     (chk_en),
    .chk_poison (pois_q[chk_idx]),
    .chk_idx    (chk_idx),
    .trap_req   (kind == WR_TRAP),
    .wr_idx     (wr_idx),
    .exc_valid  (exc_valid),
    .exc_idx    (exc_idx),
    .recov_req  (recov_req),
    .recov_idx  (recov_idx),
    .trap_valid (trap_valid),
    .trap_idx   (trap_idx)
  );

  assert_nonspec_fault_traps_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && wr_fault && !wr_spec) |=> (trap_valid && trap_idx == $past(wr_idx)));

  assert_quiet_reads_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!(rd0_en && !rd0_spec) && !(rd1_en && !rd1_spec)) |=> !exc_valid);

  assert_used_poison_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd0_en && !rd0_spec && rd0_poison) |=> (exc_valid && exc_idx == $past(rd0_idx)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_core_n) |-> (!trap_valid && !exc_valid && !recov_req));
endmodule

// File: tb/sim_deferred_fault_regfile.sv
module sim_deferred_fault_regfile;
  localparam int NR = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_en = 0, wr_spec = 0, wr_fault = 0, wr_fatal = 0;
  logic [IW-1:0] wr_idx = '0, rd0_idx = '0, rd1_idx = '0, chk_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd0_en = 0, rd0_spec = 0, rd1_en = 0, rd1_spec = 0, chk_en = 0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic rd0_poison, rd1_poison, trap_valid, exc_valid, recov_req;
  logic [IW-1:0] trap_idx, exc_idx, recov_idx;

  deferred_fault_regfile #(.NUM_REGS(NR), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_spec(wr_spec), .wr_fault(wr_fault), .wr_fatal(wr_fatal),
    .rd0_en(rd0_en), .rd0_spec(rd0_spec), .rd0_idx(rd0_idx),
    .rd0_data(rd0_data), .rd0_poison(rd0_poison),
    .rd1_en(rd1_en), .rd1_spec(rd1_spec), .rd1_idx(rd1_idx),
    .rd1_data(rd1_data), .rd1_poison(rd1_poison),
    .chk_en(chk_en), .chk_idx(chk_idx),
    .trap_valid(trap_valid), .trap_idx(trap_idx),
    .exc_valid(exc_valid), .exc_idx(exc_idx),
    .recov_req(recov_req), .recov_idx(recov_idx)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [IW-1:0] idx;
    logic [DW-1:0] data;
    logic          spec;
    logic          fault;
    logic          fatal;
    logic [DW-1:0] xdata;
    logic          xpois;
    logic          xtrap;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd3, 32'hA5A50003, 1'b0, 1'b0, 1'b0, 32'hA5A50003, 1'b0, 1'b0},
    '{4'd4, 32'h00001234, 1'b1, 1'b0, 1'b0, 32'h00001234, 1'b0, 1'b0},
    '{4'd3, 32'h0000DEAD, 1'b1, 1'b1, 1'b1, 32'hA5A50003, 1'b1, 1'b0},
    '{4'd4, 32'h0000BEEF, 1'b1, 1'b1, 1'b0, 32'h00001234, 1'b0, 1'b1},
    '{4'd4, 32'h0000CAFE, 1'b0, 1'b1, 1'b1, 32'h00001234, 1'b0, 1'b1},
    '{4'd3, 32'h00000077, 1'b0, 1'b0, 1'b0, 32'h00000077, 1'b0, 1'b0},
    '{4'd5, 32'h00005555, 1'b1, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0},
    '{4'd6, 32'h00006666, 1'b1, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0}
  };

  task automatic idle();
    wr_en = 0; wr_fault = 0; wr_spec = 0; wr_fatal = 0;
    rd0_en = 0; rd0_spec = 0; rd1_en = 0; rd1_spec = 0; chk_en = 0;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1 outputs in reset", {61'd0, trap_valid, exc_valid, recov_req}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd0_idx = 4'd3; rd1_idx = 4'd15;
    #1;
    check("R1 rd0 after reset", {31'd0, rd0_poison, rd0_data}, 64'd0);
    check("R1 rd1 after reset", {31'd0, rd1_poison, rd1_data}, 64'd0);

    // table of write vectors (R2, R3, R4)
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wr_en = 1; wr_idx = VEC[k].idx; wr_data = VEC[k].data;
      wr_spec = VEC[k].spec; wr_fault = VEC[k].fault; wr_fatal = VEC[k].fatal;
      rd0_idx = VEC[k].idx;
      @(posedge clk);
      #1;
      check($sformatf("R2/R3/R4 vec%0d data", k), {32'd0, rd0_data}, {32'd0, VEC[k].xdata});
      check($sformatf("R3 vec%0d tag", k), {63'd0, rd0_poison}, {63'd0, VEC[k].xpois});
      check($sformatf("R4 vec%0d trap", k), {63'd0, trap_valid}, {63'd0, VEC[k].xtrap});
      if (VEC[k].xtrap)
        check($sformatf("R4 vec%0d trap_idx", k), {60'd0, trap_idx}, {60'd0, VEC[k].idx});
      @(negedge clk);
      idle();
    end
    @(negedge clk);
    #1;
    check("R4 trap is one cycle", {63'd0, trap_valid}, 64'd0);

    // R5: non-speculative read of tagged r5 on port 0
    @(negedge clk);
    rd0_en = 1; rd0_idx = 4'd5;
    @(posedge clk); #1;
    check("R5 exc_valid", {63'd0, exc_valid}, 64'd1);
    check("R5 exc_idx", {60'd0, exc_idx}, 64'd5);
    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R5 exc one cycle", {63'd0, exc_valid}, 64'd0);

    // R5: port 1 alone
    @(negedge clk);
    rd1_en = 1; rd1_idx = 4'd6;
    @(posedge clk); #1;
    check("R5 port1 exc_idx", {59'd0, exc_valid, exc_idx}, {59'd0, 1'b1, 4'd6});
    @(negedge clk); idle();

    // R6: speculative read of tagged r6 passes tag, no exception
    rd1_en = 1; rd1_spec = 1; rd1_idx = 4'd6;
    #1;
    check("R6 rd1_poison", {63'd0, rd1_poison}, 64'd1);
    @(posedge clk); #1;
    check("R6 no exc", {63'd0, exc_valid}, 64'd0);
    @(negedge clk); idle();

    // R9: disabled read of tagged r5
    rd0_en = 0; rd0_idx = 4'd5;
    @(posedge clk); #1;
    check("R9 no exc", {63'd0, exc_valid}, 64'd0);
    @(negedge clk); idle();

    // R7: both ports tagged, port 0 wins
    rd0_en = 1; rd0_idx = 4'd6; rd1_en = 1; rd1_idx = 4'd5;
    @(posedge clk); #1;
    check("R7 single exc port0", {59'd0, exc_valid, exc_idx}, {59'd0, 1'b1, 4'd6});
    @(negedge clk); idle();

    // R8: check tagged r5, then clean r3
    chk_en = 1; chk_idx = 4'd5;
    @(posedge clk); #1;
    check("R8 recov tagged", {59'd0, recov_req, recov_idx}, {59'd0, 1'b1, 4'd5});
    @(negedge clk);
    chk_idx = 4'd3;
    @(posedge clk); #1;
    check("R8 clean no recov", {63'd0, recov_req}, 64'd0);
    @(negedge clk); idle();

    // R2: normal write clears tag of r5
    wr_en = 1; wr_idx = 4'd5; wr_data = 32'h0BADF00D;
    @(negedge clk); idle();
    rd0_en = 1; rd0_idx = 4'd5;
    #1;
    check("R2 tag cleared", {31'd0, rd0_poison, rd0_data}, {31'd0, 1'b0, 32'h0BADF00D});
    @(posedge clk); #1;
    check("R2 no exc on cleared", {63'd0, exc_valid}, 64'd0);
    @(negedge clk); idle();

    // R1: mid-run reset clears tags and data
    rst_n = 0;
    #1;
    rd0_idx = 4'd6; rd1_idx = 4'd3;
    #1;
    check("R1 r6 cleared by reset", {31'd0, rd0_poison, rd0_data}, 64'd0);
    check("R1 r3 cleared by reset", {31'd0, rd1_poison, rd1_data}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule